// File: doc/BRIEF.md
# Triggered multi-channel conversion sequencer

This block is the register front end of a multi-channel analog-to-digital converter. Software configures it over a simple word-addressed bus. It sets a mode word, and it turns channels and interrupt sources on and off through separate set and clear registers. A conversion round starts from a software start bit or from a rising edge on one selected hardware trigger line. In each round the block walks the channels that were enabled at the trigger, lowest number first. It asks the converter core for one channel at a time and waits for a done pulse before it asks for the next.

The block stores every result in a per-channel data register and in a last-result register. It raises an end-of-conversion flag that a read of the data register clears. It also keeps overrun flags that a read of the overrun register clears. The interrupt line is the OR of the flagged channels that are unmasked. A prescaler produces the clock-enable strobe for the converter core. A software reset clears the configuration but keeps the conversion results. The first 16 results after power-up come from a core that is still settling, and the block drops them.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A write to CHSET (addr 2) sets, and a write to CHCLR (addr 3), clears the channel-status bits (addr 4) where the data has ones; other bits keep their value, so the most recent write to a bit wins.
- R2: IESET (addr 5) and IECLR (addr 6) set and clear the interrupt mask (addr 7) the same way; `irq` is high exactly when some channel has both its mask bit and its end-of-conversion bit set.
- R3: A data register (addr 16+n) changes only when a kept result for channel n arrives, and then holds that result.
- R4: The end-of-conversion bit n (addr 8) is set by a kept result for channel n and cleared by a read of addr 16+n; when both happen on the same edge, the set wins.
- R5: Overrun bit n (addr 9) is set when a kept result for channel n arrives while its end-of-conversion bit is still one; a read of addr 9 clears all overrun bits.
- R6: With mode bit 9 at 0, only a write to addr 0 with bit 0 set starts a round. With mode bit 9 at 1, only a rising edge on `trig_in[mode[11:10]]` starts one, and that start is seen on the third clock edge after the input rises.
- R7: A round converts the channels enabled at the trigger, one request at a time, in ascending order. `conv_req` stays high with a steady `conv_ch` until `conv_done`.
- R8: A write to addr 0 with bit 1 set clears mode, channel status, interrupt mask and overrun bits, and it aborts a running round. Data registers, end-of-conversion bits and the last-result register are kept.
- R9: `conv_clk_en` pulses for one cycle every 2*(P+1) clocks, where P is mode bits [7:0].
- R10: With mode bit 8 at 0, the full 12-bit result is stored. With mode bit 8 at 1, the stored value is the result shifted right by two.
- R11: The first 16 done pulses after power-on reset update no register and set no flag.
- R12: The last-result register (addr 10) holds the latest kept result, with the value in bits [11:0] and the channel in bits [15:12].
- R13: A trigger that arrives while a round is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects happen on the edge) |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as the address |
| trig_in | input | 4 | Asynchronous hardware trigger lines |
| conv_clk_en | output | 1 | Converter clock-enable strobe |
| conv_req | output | 1 | Conversion request |
| conv_ch | output | 4 | Channel being requested |
| conv_done | input | 1 | One-cycle completion pulse from the core |
| conv_data | input | 12 | Raw result, valid with conv_done |
| irq | output | 1 | Interrupt request |

## Verification
Each result has a fixed latency:
- A register write is visible from the next edge. Read data is combinational in the cycle the address is driven.
- A software start sets the busy state on the write edge, and `conv_req` rises on the edge after that.
- A hardware edge is acted on at the third edge after the input rises.
- A done pulse updates the data register, the flags and `irq` on the edge that samples it.

The bench mirrors these latencies in a behavioural model that is updated on every rising edge. It compares `conv_req`, `conv_ch`, `irq` and `conv_clk_en` at each falling edge. Register reads are compared while the read address is held, before the edge that applies the read's side effect.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned BUS_W  = 16;
  localparam int unsigned TSEL_W = 2;

  localparam logic [5:0] ADR_CTRL   = 6'd0;
  localparam logic [5:0] ADR_MODE   = 6'd1;
  localparam logic [5:0] ADR_CHSET  = 6'd2;
  localparam logic [5:0] ADR_CHCLR  = 6'd3;
  localparam logic [5:0] ADR_CHSTAT = 6'd4;
  localparam logic [5:0] ADR_IESET  = 6'd5;
  localparam logic [5:0] ADR_IECLR  = 6'd6;
  localparam logic [5:0] ADR_IEMASK = 6'd7;
  localparam logic [5:0] ADR_EOC    = 6'd8;
  localparam logic [5:0] ADR_OVR    = 6'd9;
  localparam logic [5:0] ADR_LAST   = 6'd10;
  localparam logic [5:0] ADR_DATA0  = 6'd16;

  localparam int unsigned CTRL_START = 0;
  localparam int unsigned CTRL_SRST  = 1;

  typedef struct packed {
    logic [TSEL_W-1:0] tsel;
    logic              hw_en;
    logic              lowres;
    logic [7:0]        pre;
  } mode_t;

  localparam int unsigned MODE_W = $bits(mode_t);
endpackage

// File: rtl/adc_seq_prescaler.sv
module adc_seq_prescaler #(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] pre,
  output logic          clk_en
);
  localparam int unsigned CNTW = PW + 1;

  logic [CNTW-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim    = {pre, 1'b1};
    clk_en = (cnt_q == lim);
    cnt_d  = (cnt_q >= lim) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R9: a strobe is never followed by another on the next cycle
  p_strobe_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |=> !clk_en);
endmodule

// File: rtl/adc_seq_trigger.sv
module adc_seq_trigger #(
  parameter int unsigned NTRIG = 4,
  parameter int unsigned SW    = $clog2(NTRIG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTRIG-1:0] trig_in,
  input  logic [SW-1:0]    sel,
  input  logic             hw_en,
  input  logic             sw_start,
  output logic             trig_evt
);
  logic [NTRIG-1:0] s1_q, s2_q, s3_q;
  logic [NTRIG-1:0] rise;

  always_comb begin
    rise     = s2_q & ~s3_q;
    trig_evt = hw_en ? rise[sel] : sw_start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= trig_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  // R6: in hardware mode, a software start alone never fires
  p_sw_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_en && !s2_q[sel]) |-> !trig_evt);
endmodule

// File: rtl/adc_seq_engine.sv
module adc_seq_engine #(
  parameter int unsigned NCH   = 16,
  parameter int unsigned CW    = $clog2(NCH),
  parameter int unsigned DW    = 12,
  parameter int unsigned NDISC = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           abort,
  input  logic           trig_evt,
  input  logic [NCH-1:0] chan_en,
  output logic           conv_req,
  output logic [CW-1:0]  conv_ch,
  input  logic           conv_done,
  input  logic [DW-1:0]  conv_data,
  output logic           res_valid,
  output logic [CW-1:0]  res_ch,
  output logic [DW-1:0]  res_data
);
  localparam int unsigned DCW = $clog2(NDISC + 1);

  logic           busy_q, busy_d, req_q, req_d;
  logic [NCH-1:0] pend_q, pend_d;
  logic [CW-1:0]  ch_q, ch_d;
  logic [DCW-1:0] disc_q, disc_d;
  logic           settled, got;

  function automatic logic [CW-1:0] first_set(input logic [NCH-1:0] p);
    logic [CW-1:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (p[i]) r = CW'(i);
    return r;
  endfunction

  always_comb begin
    settled   = (disc_q == DCW'(NDISC));
    got       = req_q && conv_done;
    res_valid = got && settled;
    res_ch    = ch_q;
    res_data  = conv_data;
    conv_req  = req_q;
    conv_ch   = ch_q;
    disc_d    = (got && !settled) ? disc_q + 1'b1 : disc_q;

    busy_d = busy_q;
    req_d  = req_q;
    pend_d = pend_q;
    ch_d   = ch_q;
    if (abort) begin
      busy_d = 1'b0;
      req_d  = 1'b0;
      pend_d = '0;
    end else if (!busy_q) begin
      if (trig_evt && (chan_en != '0)) begin
        busy_d = 1'b1;
        pend_d = chan_en;
      end
    end else if (!req_q) begin
      if (pend_q == '0) begin
        busy_d = 1'b0;
      end else begin
        req_d = 1'b1;
        ch_d  = first_set(pend_q);
      end
    end else if (conv_done) begin
      req_d        = 1'b0;
      pend_d[ch_q] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      req_q  <= 1'b0;
      pend_q <= '0;
      ch_q   <= '0;
      disc_q <= '0;
    end else begin
      busy_q <= busy_d;
      req_q  <= req_d;
      pend_q <= pend_d;
      ch_q   <= ch_d;
      disc_q <= disc_d;
    end
  end

  // R7: the request is held with a steady channel until it completes
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !conv_done && !abort) |=> (conv_req && $stable(conv_ch)));
  // R7: only channels still outstanding in this round are requested
  p_req_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> pend_q[conv_ch]);
  // R13: a running round never gains channels
  p_no_retrigger_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !abort) |=> ((pend_q & ~$past(pend_q)) == '0));
  // R11: nothing is kept before the settling count is reached
  p_discard_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !settled |-> !res_valid);
endmodule

// File: rtl/adc_seq_results.sv
module adc_seq_results #(
  parameter int unsigned NCH = 16,
  parameter int unsigned CW  = $clog2(NCH),
  parameter int unsigned DW  = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    abort,
  input  logic                    res_valid,
  input  logic [CW-1:0]           res_ch,
  input  logic [DW-1:0]           res_data,
  input  logic                    lowres,
  input  logic                    data_rd,
  input  logic [CW-1:0]           data_rd_ch,
  input  logic                    ovr_rd,
  output logic [NCH-1:0]          eoc,
  output logic [NCH-1:0]          ovr,
  output logic [NCH-1:0][DW-1:0]  data_q,
  output logic [CW-1:0]           last_ch,
  output logic [DW-1:0]           last_data
);
  logic [DW-1:0]  stored;
  logic [NCH-1:0] eoc_q, eoc_d, ovr_q, ovr_d;
  logic [CW-1:0]  lch_d;
  logic [DW-1:0]  ldat_d;

  always_comb stored = lowres ? {2'b00, res_data[DW-1:2]} : res_data;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    logic [DW-1:0] dat_d;
    always_comb begin
      hit      = res_valid && (res_ch == CW'(i));
      dat_d    = hit ? stored : data_q[i];
      eoc_d[i] = hit ? 1'b1 : ((data_rd && data_rd_ch == CW'(i)) ? 1'b0 : eoc_q[i]);
      if (abort)                 ovr_d[i] = 1'b0;
      else if (hit && eoc_q[i])  ovr_d[i] = 1'b1;
      else if (ovr_rd)           ovr_d[i] = 1'b0;
      else                       ovr_d[i] = ovr_q[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) data_q[i] <= '0;
      else        data_q[i] <= dat_d;
    end
    // R3: a data register moves only on a result for its own channel
    p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(res_valid && res_ch == CW'(i)) |=> $stable(data_q[i]));
  end

  always_comb begin
    lch_d  = res_valid ? res_ch : last_ch;
    ldat_d = res_valid ? stored : last_data;
    eoc    = eoc_q;
    ovr    = ovr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoc_q     <= '0;
      ovr_q     <= '0;
      last_ch   <= '0;
      last_data <= '0;
    end else begin
      eoc_q     <= eoc_d;
      ovr_q     <= ovr_d;
      last_ch   <= lch_d;
      last_data <= ldat_d;
    end
  end

  // R4: a kept result always leaves its flag set
  p_eoc_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> eoc[$past(res_ch)]);
  // R5: a status read with no new result empties the overrun register
  p_ovr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_rd && !res_valid) |=> (ovr == '0));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned NCH   = 16,
  parameter int unsigned DW    = 12,
  parameter int unsigned NDISC = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [5:0]              bus_addr,
  input  logic [BUS_W-1:0]        bus_wdata,
  output logic [BUS_W-1:0]        bus_rdata,
  input  logic [(1<<TSEL_W)-1:0]  trig_in,
  output logic                    conv_clk_en,
  output logic                    conv_req,
  output logic [$clog2(NCH)-1:0]  conv_ch,
  input  logic                    conv_done,
  input  logic [DW-1:0]           conv_data,
  output logic                    irq
);
  localparam int unsigned CW    = $clog2(NCH);
  localparam int unsigned NTRIG = 1 << TSEL_W;
  localparam logic [6:0]  DEND  = 7'(ADR_DATA0) + 7'(NCH);

  mode_t          mode_q, mode_d;
  logic [NCH-1:0] chs_q, chs_d, mask_q, mask_d;
  logic           wr_ctrl, sw_start, srst, trig_evt;
  logic           data_sel, data_rd, ovr_rd;
  logic [CW-1:0]  data_idx;
  logic [NCH-1:0] ch_set, ch_clr, ie_set, ie_clr, eoc, ovr;
  logic [NCH-1:0][DW-1:0] data_q;
  logic           res_valid;
  logic [CW-1:0]  res_ch, last_ch;
  logic [DW-1:0]  res_data, last_data;

  always_comb begin
    wr_ctrl  = bus_wr && (bus_addr == ADR_CTRL);
    sw_start = wr_ctrl && bus_wdata[CTRL_START];
    srst     = wr_ctrl && bus_wdata[CTRL_SRST];
    ch_set   = (bus_wr && bus_addr == ADR_CHSET) ? bus_wdata[NCH-1:0] : '0;
    ch_clr   = (bus_wr && bus_addr == ADR_CHCLR) ? bus_wdata[NCH-1:0] : '0;
    ie_set   = (bus_wr && bus_addr == ADR_IESET) ? bus_wdata[NCH-1:0] : '0;
    ie_clr   = (bus_wr && bus_addr == ADR_IECLR) ? bus_wdata[NCH-1:0] : '0;
    data_sel = ({1'b0, bus_addr} >= 7'(ADR_DATA0)) && ({1'b0, bus_addr} < DEND);
    data_idx = bus_addr[CW-1:0];
    data_rd  = bus_rd && data_sel;
    ovr_rd   = bus_rd && (bus_addr == ADR_OVR);
    irq      = |(eoc & mask_q);
  end

  always_comb begin
    if (srst) begin
      mode_d = '0;
      chs_d  = '0;
      mask_d = '0;
    end else begin
      mode_d = (bus_wr && bus_addr == ADR_MODE) ? mode_t'(bus_wdata[MODE_W-1:0]) : mode_q;
      chs_d  = (chs_q | ch_set) & ~ch_clr;
      mask_d = (mask_q | ie_set) & ~ie_clr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      chs_q  <= '0;
      mask_q <= '0;
    end else begin
      mode_q <= mode_d;
      chs_q  <= chs_d;
      mask_q <= mask_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADR_MODE:   bus_rdata[MODE_W-1:0] = mode_q;
      ADR_CHSTAT: bus_rdata[NCH-1:0]    = chs_q;
      ADR_IEMASK: bus_rdata[NCH-1:0]    = mask_q;
      ADR_EOC:    bus_rdata[NCH-1:0]    = eoc;
      ADR_OVR:    bus_rdata[NCH-1:0]    = ovr;
      ADR_LAST:   bus_rdata[CW+DW-1:0]  = {last_ch, last_data};
      default:    if (data_sel) bus_rdata[DW-1:0] = data_q[data_idx];
    endcase
  end

  adc_seq_prescaler #(.PW(8)) u_pre (
    .clk(clk), .rst_n(rst_n), .pre(mode_q.pre), .clk_en(conv_clk_en));

  adc_seq_trigger #(.NTRIG(NTRIG), .SW(TSEL_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .sel(mode_q.tsel),
    .hw_en(mode_q.hw_en), .sw_start(sw_start), .trig_evt(trig_evt));

  adc_seq_engine #(.NCH(NCH), .CW(CW), .DW(DW), .NDISC(NDISC)) u_eng (
    .clk(clk), .rst_n(rst_n), .abort(srst), .trig_evt(trig_evt),
    .chan_en(chs_q), .conv_req(conv_req), .conv_ch(conv_ch),
    .conv_done(conv_done), .conv_data(conv_data), .res_valid(res_valid),
    .res_ch(res_ch), .res_data(res_data));

  adc_seq_results #(.NCH(NCH), .CW(CW), .DW(DW)) u_res (
    .clk(clk), .rst_n(rst_n), .abort(srst), .res_valid(res_valid),
    .res_ch(res_ch), .res_data(res_data), .lowres(mode_q.lowres),
    .data_rd(data_rd), .data_rd_ch(data_idx), .ovr_rd(ovr_rd),
    .eoc(eoc), .ovr(ovr), .data_q(data_q), .last_ch(last_ch),
    .last_data(last_data));

  // R8: software reset leaves the configuration cleared
  p_srst_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (mode_q == '0 && chs_q == '0 && mask_q == '0 && ovr == '0));
  // R1: a set write always leaves the written bits on
  p_chset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_set != '0 && !srst) |=> ((chs_q & $past(ch_set)) == $past(ch_set)));
endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, bus_wr, bus_rd, conv_done;
  logic [5:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic [3:0]  trig_in, conv_ch;
  logic [11:0] conv_data;
  logic        conv_clk_en, conv_req, irq;

  adc_seq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .trig_in(trig_in), .conv_clk_en(conv_clk_en), .conv_req(conv_req),
    .conv_ch(conv_ch), .conv_done(conv_done), .conv_data(conv_data),
    .irq(irq));

  int n_cmp = 0, n_bad = 0;

  // behavioural reference state
  logic [15:0] m_chs, m_mask, m_eoc, m_ovr, m_pend, m_last;
  logic [11:0] m_mode;
  logic [11:0] m_dat [16];
  logic [3:0]  m_s1, m_s2, m_s3;
  bit          m_busy, m_req;
  int          m_ch, m_disc, m_cnt, lat, seqn;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lowest(input logic [15:0] p);
    int r = 0;
    for (int i = 15; i >= 0; i--) if (p[i]) r = i;
    return r;
  endfunction

  function automatic logic [15:0] exp_rd(input logic [5:0] a);
    case (a)
      6'd1:  return {4'h0, m_mode};
      6'd4:  return m_chs;
      6'd7:  return m_mask;
      6'd8:  return m_eoc;
      6'd9:  return m_ovr;
      6'd10: return m_last;
      default: return (a >= 6'd16 && a < 6'd32) ? {4'h0, m_dat[a-6'd16]} : 16'h0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic wr0, sres, st, trig, got, keep, old_eoc;
    logic [3:0] rise;
    logic [11:0] v;
    if (!rst_n) begin
      m_chs = 0; m_mask = 0; m_eoc = 0; m_ovr = 0; m_pend = 0; m_last = 0;
      m_mode = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_busy = 0; m_req = 0;
      m_ch = 0; m_disc = 0; m_cnt = 0;
      for (int i = 0; i < 16; i++) m_dat[i] = 0;
    end else begin
      wr0  = bus_wr && bus_addr == 6'd0;
      sres = wr0 && bus_wdata[1];
      st   = wr0 && bus_wdata[0];
      rise = m_s2 & ~m_s3;
      trig = m_mode[9] ? rise[m_mode[11:10]] : st;
      got  = m_req && conv_done;
      keep = got && (m_disc == 16);
      old_eoc = m_eoc[m_ch];
      // results (R3 R4 R5 R10 R11 R12)
      if (bus_rd && bus_addr >= 6'd16 && bus_addr < 6'd32) m_eoc[bus_addr-6'd16] = 1'b0;
      if (sres) m_ovr = 0;
      else begin
        if (bus_rd && bus_addr == 6'd9) m_ovr = 0;
        if (keep && old_eoc) m_ovr[m_ch] = 1'b1;
      end
      if (keep) begin
        v = m_mode[8] ? (conv_data >> 2) : conv_data;
        m_dat[m_ch] = v;
        m_last = {4'(m_ch), v};
        m_eoc[m_ch] = 1'b1;
      end
      if (got && m_disc < 16) m_disc++;
      // sequencing (R6 R7 R13)
      if (sres) begin m_busy = 0; m_req = 0; m_pend = 0; end
      else if (!m_busy) begin
        if (trig && m_chs != 0) begin m_busy = 1; m_pend = m_chs; end
      end else if (!m_req) begin
        if (m_pend == 0) m_busy = 0;
        else begin m_req = 1; m_ch = lowest(m_pend); end
      end else if (conv_done) begin
        m_req = 0; m_pend[m_ch] = 1'b0;
      end
      // prescaler (R9)
      m_cnt = (m_cnt >= 2 * int'(m_mode[7:0]) + 1) ? 0 : m_cnt + 1;
      // configuration (R1 R2 R8)
      if (sres) begin m_mode = 0; m_chs = 0; m_mask = 0; end
      else if (bus_wr) begin
        case (bus_addr)
          6'd1: m_mode = bus_wdata[11:0];
          6'd2: m_chs  = m_chs | bus_wdata;
          6'd3: m_chs  = m_chs & ~bus_wdata;
          6'd5: m_mask = m_mask | bus_wdata;
          6'd6: m_mask = m_mask & ~bus_wdata;
          default: ;
        endcase
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = trig_in;
    end
  end

  // per-clock comparison and converter stand-in
  always @(negedge clk) begin
    if (rst_n) begin
      check("R7 conv_req", {15'h0, conv_req}, {15'h0, m_req});
      if (m_req) check("R7 conv_ch", {12'h0, conv_ch}, 16'(m_ch));
      check("R2 irq", {15'h0, irq}, {15'h0, |(m_eoc & m_mask)});
      check("R9 clk_en", {15'h0, conv_clk_en},
            {15'h0, m_cnt == 2 * int'(m_mode[7:0]) + 1});
    end
    if (!rst_n || conv_done) begin
      conv_done = 1'b0; lat = 0;
    end else if (conv_req) begin
      lat++;
      if (lat == 3) begin
        conv_done = 1'b1;
        conv_data = 12'((int'(conv_ch) * 300 + seqn * 37) & 12'hfff);
        seqn++;
        lat = 0;
      end
    end else lat = 0;
  end

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [5:0] a, output logic [15:0] v);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1;
    v = bus_rdata;
    check(tag, v, exp_rd(a));
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_busy);
    repeat (2) @(negedge clk);
  endtask

  task automatic quiet(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      check(tag, {15'h0, conv_req}, 16'h0);
    end
  endtask

  task automatic pulse(input int b);
    @(negedge clk); trig_in[b] = 1'b1;
    repeat (2) @(negedge clk); trig_in[b] = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    rst_n = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    trig_in = 0; conv_done = 0; conv_data = 0; lat = 0; seqn = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    rd("R1 reset chstat", 6'd4, v); check("R1 reset chstat", v, 16'h0);
    rd("R8 reset mode", 6'd1, v);   check("R8 reset mode", v, 16'h0);
    rd("R4 reset eoc", 6'd8, v);    check("R4 reset eoc", v, 16'h0);
    rd("R12 reset last", 6'd10, v); check("R12 reset last", v, 16'h0);
    // R9: prescale 2, strobe every 6 clocks
    wr(6'd1, 16'h0002);
    repeat (20) @(negedge clk);
    // R11: sixteen results are dropped
    wr(6'd2, 16'hffff);
    wr(6'd0, 16'h0001);
    wait_idle();
    rd("R11 eoc", 6'd8, v);    check("R11 eoc", v, 16'h0);
    rd("R11 data5", 6'd21, v); check("R11 data5", v, 16'h0);
    rd("R11 last", 6'd10, v);  check("R11 last", v, 16'h0);
    // R1: set and clear pairs
    wr(6'd3, 16'hfff0);
    rd("R1 clr", 6'd4, v); check("R1 clr", v, 16'h000f);
    wr(6'd2, 16'h0100);
    wr(6'd3, 16'h0001);
    wr(6'd2, 16'h0001);
    rd("R1 set", 6'd4, v); check("R1 set", v, 16'h010f);
    // R2: interrupt mask
    wr(6'd5, 16'h0003);
    wr(6'd6, 16'h0001);
    rd("R2 mask", 6'd7, v); check("R2 mask", v, 16'h0002);
    // R7, R3, R4, R12: one round over channels 0..3 and 8
    wr(6'd0, 16'h0001);
    wait_idle();
    rd("R4 eoc", 6'd8, v); check("R4 eoc", v, 16'h010f);
    rd("R12 last", 6'd10, v); check("R12 last ch", {12'h0, v[15:12]}, 16'h0008);
    rd("R3 data1", 6'd17, v);
    rd("R4 eoc after read", 6'd8, v); check("R4 eoc after read", v, 16'h010d);
    @(negedge clk); check("R2 irq low", {15'h0, irq}, 16'h0);
    // R5: overrun
    wr(6'd0, 16'h0001);
    wait_idle();
    rd("R5 ovr", 6'd9, v); check("R5 ovr", v, 16'h010d);
    rd("R5 ovr cleared", 6'd9, v); check("R5 ovr cleared", v, 16'h0);
    rd("R3 data4", 6'd20, v); check("R3 data4", v, 16'h0);
    rd("R3 data8", 6'd24, v);
    // R6, R13: hardware trigger on line 2
    wr(6'd1, 16'h0a02);
    wr(6'd0, 16'h0001);
    quiet("R6 start ignored", 10);
    pulse(1);
    quiet("R6 other line ignored", 10);
    pulse(2);
    repeat (8) @(negedge clk);
    check("R6 hw round", {15'h0, conv_req | m_busy}, 16'h1);
    pulse(2);
    wait_idle();
    quiet("R13 busy trigger ignored", 10);
    rd("R6 eoc", 6'd8, v);
    // R10: reduced resolution
    wr(6'd1, 16'h0102);
    wr(6'd0, 16'h0001);
    wait_idle();
    rd("R10 data8", 6'd24, v); check("R10 top bits", {14'h0, v[11:10]}, 16'h0);
    rd("R10 last", 6'd10, v);
    // R8: software reset keeps results
    wr(6'd0, 16'h0001);
    repeat (2) @(negedge clk);
    wr(6'd0, 16'h0002);
    quiet("R8 abort", 5);
    rd("R8 mode", 6'd1, v);  check("R8 mode", v, 16'h0);
    rd("R8 chs", 6'd4, v);   check("R8 chs", v, 16'h0);
    rd("R8 mask", 6'd7, v);  check("R8 mask", v, 16'h0);
    rd("R8 ovr", 6'd9, v);   check("R8 ovr", v, 16'h0);
    rd("R8 eoc kept", 6'd8, v);
    rd("R8 data kept", 6'd16, v);
    rd("R8 last kept", 6'd10, v);
    repeat (5) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule